// File: doc/BRIEF.md
# Debug Port Attach and Access-Port Scan Sequencer

This block drives a serial-wire debug link through a lower transaction engine to bring a target's debug port up and to list its access ports. It sends a fixed series of single register transfers over a command/response handshake. First it reads the debug-port identification word. Next it writes the power-up request bits into the control/status register and polls that register until both acknowledge bits are set. It then steps through every access-port select value and reads the identification register of each one.

An access-port read is posted. For each port the sequencer writes the select register to point at the identification register's bank. It then reads the read buffer twice. The first read only pushes the transfer through, and the second read returns the value. Each port's result is streamed out as a one-cycle report. The run ends in one of two states. The first is a done state. The second is an error state that records the failure class and the step that failed.

Top module: `dpscan_top`

## Requirements
- R1: While `rst` is high, and after it is released, `busy`, `done`, `err`, `cmd_valid`, `dpid_valid` and `apid_valid` are low until `start` is seen.
- R2: The first transfer of a run is a read of register code 0 (`cmd_addr`=0, `cmd_write`=0). An OK reply loads `dpid_value` with the reply data and sets `dpid_valid`.
- R3: After the identification read, the sequencer writes 0x5000_0000 (request bits 28 and 30) to register code 1. It then reads code 1 until bits 29 and 31 are both set. If `POLL_MAX` polls pass without both bits set, the run ends with error code 4. Success on the last permitted poll still continues the run.
- R4: For each port, the sequencer writes register code 2 with {select[7:0], 16'h0, 4'hF, 4'h0}. It then makes two reads of register code 3, and the reported value is the data of the second read.
- R5: Each port produces a one-cycle `apid_valid` pulse. `apid_sel` counts up from 0 to `AP_LAST`, and `apid_present` is high exactly when `apid_value` is non-zero. `done` rises together with the report for `AP_LAST`.
- R6: Acknowledge code 3'b010 (WAIT) reissues the same transfer. Each transfer may be reissued up to `WAIT_MAX` times, and the next WAIT ends the run with error code 2.
- R7: Acknowledge code 3'b100 (FAULT) stops the run with error code 1. `err_step` gives the failing step: 0 id read, 1 power write, 2 power poll, 3 select write, 4 commit read, 5 result read. Acknowledge 3'b001 is OK.
- R8: Any acknowledge other than OK, WAIT or FAULT stops the run with error code 3.
- R9: `start` has no effect while `busy` is high. In the idle, done or error state, `start` begins a new run and clears `done`, `err` and `dpid_valid` on the next edge.
- R10: Only one transfer is in flight at a time. The command fields stay stable while `cmd_valid` is high and `cmd_ready` is low.
- R11: `done` and `err` are never high together, and each stays set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (idle, done or error state only) |
| cmd_valid | output | 1 | Transfer request to the link engine |
| cmd_ready | input | 1 | Engine accepts the request |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_addr | output | 2 | Register code (address bits 3:2) |
| cmd_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Reply from the engine |
| rsp_ack | input | 3 | Acknowledge code of the reply |
| rsp_rdata | input | 32 | Read data of the reply |
| dpid_value | output | 32 | Captured debug-port identification |
| dpid_valid | output | 1 | `dpid_value` holds this run's value |
| apid_valid | output | 1 | One-cycle port report strobe |
| apid_sel | output | 8 | Select value of the reported port |
| apid_value | output | 32 | Identification word of the reported port |
| apid_present | output | 1 | Reported port exists (non-zero word) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed without error |
| err | output | 1 | Run stopped on an error |
| err_code | output | 3 | 0 none, 1 fault, 2 wait limit, 3 bad ack, 4 poll limit |
| err_step | output | 3 | Step that failed (see R7) |

## Verification
Two decisions can land on the same response: the power poll that reaches the poll limit is also the one that returns both acknowledge bits. In that case success must win. The bench sets the emulated engine to raise the acknowledges exactly on poll number `POLL_MAX` and expects a full scan and `done`. A second vector raises them one poll later and expects error code 4 after exactly `POLL_MAX` polls. The same boundary is tested for WAIT retries, with exactly `WAIT_MAX` WAIT replies and with one more than that.

// File: rtl/dpscan_pkg.sv
package dpscan_pkg;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] RA_IDR   = 2'd0;
    localparam logic [1:0] RA_CTRL  = 2'd1;
    localparam logic [1:0] RA_SEL   = 2'd2;
    localparam logic [1:0] RA_RDBUF = 2'd3;

    localparam int PWR_REQ_DBG = 28;
    localparam int PWR_ACK_DBG = 29;
    localparam int PWR_REQ_SYS = 30;
    localparam int PWR_ACK_SYS = 31;

    localparam logic [3:0] ID_BANK = 4'hF;

    typedef enum logic [2:0] {
        STEP_IDR    = 3'd0,
        STEP_PWR    = 3'd1,
        STEP_POLL   = 3'd2,
        STEP_SEL    = 3'd3,
        STEP_COMMIT = 3'd4,
        STEP_APID   = 3'd5
    } step_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_FAULT = 3'd1,
        ERR_WAIT  = 3'd2,
        ERR_PROTO = 3'd3,
        ERR_POLL  = 3'd4
    } err_e;

    typedef enum logic [2:0] {
        V_NONE, V_OK, V_RETRY, V_FAULT, V_WAIT_OUT, V_PROTO
    } verdict_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ISSUE, PH_WAIT, PH_DONE, PH_ERR
    } phase_e;

    typedef struct packed {
        logic        write;
        logic [1:0]  addr;
        logic [31:0] wdata;
    } xfer_t;

    function automatic logic [31:0] pwr_req_word();
        logic [31:0] w;
        w = '0;
        w[PWR_REQ_DBG] = 1'b1;
        w[PWR_REQ_SYS] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] sel_word(input logic [7:0] ap);
        return {ap, 16'h0000, ID_BANK, 4'h0};
    endfunction

    function automatic logic pwr_up_done(input logic [31:0] st);
        return st[PWR_ACK_DBG] & st[PWR_ACK_SYS];
    endfunction

endpackage

// File: rtl/dpscan_xfer_gen.sv
module dpscan_xfer_gen
    import dpscan_pkg::*;
(
    input  step_e       step,
    input  logic [7:0]  ap_sel,
    output xfer_t       xfer
);

    always_comb begin
        xfer = '0;
        case (step)
            STEP_IDR: begin
                xfer.write = 1'b0;
                xfer.addr  = RA_IDR;
            end
            STEP_PWR: begin
                xfer.write = 1'b1;
                xfer.addr  = RA_CTRL;
                xfer.wdata = pwr_req_word();
            end
            STEP_POLL: begin
                xfer.write = 1'b0;
                xfer.addr  = RA_CTRL;
            end
            STEP_SEL: begin
                xfer.write = 1'b1;
                xfer.addr  = RA_SEL;
                xfer.wdata = sel_word(ap_sel);
            end
            STEP_COMMIT, STEP_APID: begin
                xfer.write = 1'b0;
                xfer.addr  = RA_RDBUF;
            end
            default: xfer = '0;
        endcase
    end

endmodule

// File: rtl/dpscan_ack_eval.sv
module dpscan_ack_eval
    import dpscan_pkg::*;
#(
    parameter int WAIT_MAX = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      take,
    input  logic [2:0] ack,
    output verdict_e  verdict
);

    localparam int CW = $clog2(WAIT_MAX + 2);
    localparam logic [CW-1:0] WLIM = CW'(WAIT_MAX);

    logic [CW-1:0] wait_cnt;

    always_comb begin
        verdict = V_NONE;
        if (take) begin
            case (ack)
                ACK_OK:    verdict = V_OK;
                ACK_WAIT:  verdict = (wait_cnt == WLIM) ? V_WAIT_OUT : V_RETRY;
                ACK_FAULT: verdict = V_FAULT;
                default:   verdict = V_PROTO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wait_cnt <= '0;
        end else if (verdict == V_RETRY) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else if (verdict != V_NONE) begin
            wait_cnt <= '0;
        end
    end

    AST_WAIT_NOT_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (verdict == V_RETRY) |-> (wait_cnt < WLIM)) else $error("wait retry past limit"); // R6

endmodule

// File: rtl/dpscan_poll_ctr.sv
module dpscan_poll_ctr #(
    parameter int POLL_MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(POLL_MAX + 1);
    localparam logic [CW-1:0] PLAST = CW'(POLL_MAX - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == PLAST);

    AST_POLL_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        inc |-> !last) else $error("poll counter advanced at limit"); // R3

endmodule

// File: rtl/dpscan_top.sv
module dpscan_top
    import dpscan_pkg::*;
#(
    parameter int AP_LAST  = 255,
    parameter int WAIT_MAX = 4,
    parameter int POLL_MAX = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic        cmd_write,
    output logic [1:0]  cmd_addr,
    output logic [31:0] cmd_wdata,
    input  logic        rsp_valid,
    input  logic [2:0]  rsp_ack,
    input  logic [31:0] rsp_rdata,
    output logic [31:0] dpid_value,
    output logic        dpid_valid,
    output logic        apid_valid,
    output logic [7:0]  apid_sel,
    output logic [31:0] apid_value,
    output logic        apid_present,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [2:0]  err_code,
    output logic [2:0]  err_step
);

    localparam logic [7:0] AP_TOP = AP_LAST[7:0];

    phase_e     phase;
    step_e      step;
    logic [7:0] ap_sel;
    xfer_t      xfer;
    verdict_e   verdict;
    err_e       fail_code;
    logic       take;
    logic       launch;
    logic       poll_clr;
    logic       poll_inc;
    logic       poll_last;
    logic       pwr_ok;

    assign take   = (phase == PH_WAIT) && rsp_valid;
    assign launch = start && (phase == PH_IDLE || phase == PH_DONE || phase == PH_ERR);
    assign pwr_ok = pwr_up_done(rsp_rdata);

    dpscan_xfer_gen u_xfer (
        .step   (step),
        .ap_sel (ap_sel),
        .xfer   (xfer)
    );

    dpscan_ack_eval #(.WAIT_MAX(WAIT_MAX)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .clr     (launch),
        .take    (take),
        .ack     (rsp_ack),
        .verdict (verdict)
    );

    assign poll_clr = (verdict == V_OK) && (step == STEP_PWR);
    assign poll_inc = (verdict == V_OK) && (step == STEP_POLL) && !pwr_ok && !poll_last;

    dpscan_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk  (clk),
        .rst  (rst),
        .clr  (poll_clr || launch),
        .inc  (poll_inc),
        .last (poll_last)
    );

    always_comb begin
        fail_code = ERR_NONE;
        case (verdict)
            V_FAULT:    fail_code = ERR_FAULT;
            V_WAIT_OUT: fail_code = ERR_WAIT;
            V_PROTO:    fail_code = ERR_PROTO;
            V_OK: begin
                if (step == STEP_POLL && !pwr_ok && poll_last) begin
                    fail_code = ERR_POLL;
                end
            end
            default: fail_code = ERR_NONE;
        endcase
    end

    assign cmd_valid = (phase == PH_ISSUE);
    assign cmd_write = xfer.write;
    assign cmd_addr  = xfer.addr;
    assign cmd_wdata = xfer.wdata;
    assign busy      = (phase == PH_ISSUE) || (phase == PH_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            step         <= STEP_IDR;
            ap_sel       <= '0;
            dpid_value   <= '0;
            dpid_valid   <= 1'b0;
            apid_valid   <= 1'b0;
            apid_sel     <= '0;
            apid_value   <= '0;
            apid_present <= 1'b0;
            done         <= 1'b0;
            err          <= 1'b0;
            err_code     <= ERR_NONE;
            err_step     <= STEP_IDR;
        end else begin
            apid_valid <= 1'b0;
            if (launch) begin
                phase      <= PH_ISSUE;
                step       <= STEP_IDR;
                ap_sel     <= '0;
                dpid_valid <= 1'b0;
                done       <= 1'b0;
                err        <= 1'b0;
                err_code   <= ERR_NONE;
                err_step   <= STEP_IDR;
            end else if (phase == PH_ISSUE) begin
                if (cmd_ready) begin
                    phase <= PH_WAIT;
                end
            end else if (phase == PH_WAIT && take) begin
                if (fail_code != ERR_NONE) begin
                    phase    <= PH_ERR;
                    err      <= 1'b1;
                    err_code <= fail_code;
                    err_step <= step;
                end else if (verdict == V_RETRY) begin
                    phase <= PH_ISSUE;
                end else if (verdict == V_OK) begin
                    phase <= PH_ISSUE;
                    case (step)
                        STEP_IDR: begin
                            dpid_value <= rsp_rdata;
                            dpid_valid <= 1'b1;
                            step       <= STEP_PWR;
                        end
                        STEP_PWR: step <= STEP_POLL;
                        STEP_POLL: begin
                            if (pwr_ok) begin
                                step   <= STEP_SEL;
                                ap_sel <= '0;
                            end
                        end
                        STEP_SEL:    step <= STEP_COMMIT;
                        STEP_COMMIT: step <= STEP_APID;
                        STEP_APID: begin
                            apid_valid   <= 1'b1;
                            apid_sel     <= ap_sel;
                            apid_value   <= rsp_rdata;
                            apid_present <= |rsp_rdata;
                            if (ap_sel == AP_TOP) begin
                                phase <= PH_DONE;
                                done  <= 1'b1;
                            end else begin
                                ap_sel <= ap_sel + 1'b1;
                                step   <= STEP_SEL;
                            end
                        end
                        default: step <= STEP_IDR;
                    endcase
                end
            end
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write) && $stable(cmd_addr)
                                       && $stable(cmd_wdata))) else $error("command changed while pending"); // R10

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)) else $error("done and err together"); // R11

    AST_WAIT_REISSUE: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_valid && rsp_valid && rsp_ack == ACK_WAIT) |=>
            (err || (cmd_valid && $stable(cmd_addr) && $stable(cmd_write)))) else $error("wait not reissued"); // R6

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_valid && rsp_valid && rsp_ack == ACK_FAULT) |=>
            (err && err_code == ERR_FAULT && !busy)) else $error("fault did not stop run"); // R7

    AST_APID_AFTER_OK: assert property (@(posedge clk) disable iff (rst)
        apid_valid |-> ($past(rsp_valid) && $past(rsp_ack) == ACK_OK)) else $error("report without OK reply"); // R5

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !rsp_valid) |=> (busy && $stable(cmd_addr))) else $error("start disturbed a run"); // R9

endmodule

// File: tb/dpscan_tb_top.sv
module dpscan_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AP_LAST    = 3;
    localparam int WAIT_MAX   = 2;
    localparam int POLL_MAX   = 4;

    typedef struct packed {
        logic [31:0] idv;
        logic [3:0]  waits;
        logic [2:0]  idr_ack;
        logic [3:0]  poll_at;
        logic [8:0]  fault_sel;
        logic [2:0]  exp_err;
        logic [2:0]  exp_step;
        logic [7:0]  exp_cmds;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h2BA0_1477, 4'd0, 3'b001, 4'd1, 9'h1FF, 3'd0, 3'd0, 8'd15},
        '{32'h0BB1_1477, 4'd2, 3'b001, 4'd3, 9'h1FF, 3'd0, 3'd0, 8'd19},
        '{32'h1111_2222, 4'd3, 3'b001, 4'd1, 9'h1FF, 3'd2, 3'd0, 8'd3},
        '{32'h3333_4444, 4'd0, 3'b001, 4'd4, 9'h1FF, 3'd0, 3'd0, 8'd18},
        '{32'h5555_6666, 4'd0, 3'b001, 4'd5, 9'h1FF, 3'd4, 3'd2, 8'd6},
        '{32'h7777_8888, 4'd0, 3'b001, 4'd1, 9'd2,   3'd1, 3'd3, 8'd10},
        '{32'h9999_AAAA, 4'd1, 3'b100, 4'd1, 9'h1FF, 3'd1, 3'd0, 8'd2},
        '{32'hBBBB_CCCC, 4'd0, 3'b111, 4'd1, 9'h1FF, 3'd3, 3'd0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cmd_valid, cmd_ready, cmd_write;
    logic [1:0]  cmd_addr;
    logic [31:0] cmd_wdata;
    logic        rsp_valid;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic [31:0] dpid_value;
    logic        dpid_valid, apid_valid, apid_present, busy, done, err;
    logic [7:0]  apid_sel;
    logic [31:0] apid_value;
    logic [2:0]  err_code, err_step;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int cfg_waits, cfg_poll_at, cfg_fault_sel;
    logic [2:0]  cfg_ack;
    logic [31:0] cfg_idv;
    int n_cmd, poll_n, cur_sel, rd_after_sel, n_rep;
    bit bank_bad, ctrl_bad, first_bad;
    logic [7:0]  rep_sel [8];
    logic [31:0] rep_val [8];
    logic        rep_pres [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpscan_top #(.AP_LAST(AP_LAST), .WAIT_MAX(WAIT_MAX), .POLL_MAX(POLL_MAX)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .dpid_value(dpid_value), .dpid_valid(dpid_valid),
        .apid_valid(apid_valid), .apid_sel(apid_sel), .apid_value(apid_value),
        .apid_present(apid_present), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .err_step(err_step)
    );

    function automatic logic [31:0] ap_word(input int sel);
        return (sel % 2 == 1) ? 32'h0 : (32'h0477_0000 | 32'(sel));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // emulated link engine
    initial begin
        cmd_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_ack   = 3'b000;
        rsp_rdata = '0;
        forever begin
            @(negedge clk);
            if (cmd_valid && !rst) begin
                logic        w;
                logic [1:0]  a;
                logic [31:0] d;
                w = cmd_write; a = cmd_addr; d = cmd_wdata;
                if (n_cmd == 0 && !(w == 1'b0 && a == 2'd0)) first_bad = 1'b1;
                n_cmd++;
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                rsp_ack   = 3'b001;
                rsp_rdata = 32'h0;
                if (!w && a == 2'd0) begin
                    if (cfg_waits > 0) begin
                        cfg_waits--;
                        rsp_ack = 3'b010;
                    end else begin
                        rsp_ack   = cfg_ack;
                        rsp_rdata = cfg_idv;
                    end
                end else if (w && a == 2'd1) begin
                    if (d != 32'h5000_0000) ctrl_bad = 1'b1;
                end else if (!w && a == 2'd1) begin
                    poll_n++;
                    rsp_rdata = (poll_n == cfg_poll_at) ? 32'hF000_0000 : 32'h5000_0000;
                end else if (w && a == 2'd2) begin
                    cur_sel = int'(d[31:24]);
                    rd_after_sel = 0;
                    if (d[7:4] != 4'hF || d[23:8] != 16'h0 || d[3:0] != 4'h0) bank_bad = 1'b1;
                    if (cur_sel == cfg_fault_sel) rsp_ack = 3'b100;
                end else if (!w && a == 2'd3) begin
                    rd_after_sel++;
                    rsp_rdata = (rd_after_sel == 1) ? 32'hDEAD_BEEF : ap_word(cur_sel);
                end
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // report monitor
    initial begin
        forever begin
            @(negedge clk);
            if (apid_valid && n_rep < 8) begin
                rep_sel[n_rep]  = apid_sel;
                rep_val[n_rep]  = apid_value;
                rep_pres[n_rep] = apid_present;
                n_rep++;
            end
        end
    end

    task automatic run(input vec_t v, input bit poke);
        int cyc;
        int exp_rep;
        cfg_idv = v.idv; cfg_waits = int'(v.waits); cfg_ack = v.idr_ack;
        cfg_poll_at = int'(v.poll_at); cfg_fault_sel = int'(v.fault_sel);
        n_cmd = 0; poll_n = 0; n_rep = 0; cur_sel = 0; rd_after_sel = 0;
        bank_bad = 0; ctrl_bad = 0; first_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !err && !dpid_valid, "R9 start clears status", {29'd0, done, err, dpid_valid}, 32'd0);
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!(done || err) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 5000, "R11 run ends", 32'(cyc), 32'd5000);
        @(negedge clk);
        @(negedge clk);
        chk(done == (v.exp_err == 3'd0) && err == (v.exp_err != 3'd0), "R11 end state",
            {30'd0, done, err}, {30'd0, v.exp_err == 3'd0, v.exp_err != 3'd0});
        chk(err_code == v.exp_err, "R7 R6 R8 R3 error code", 32'(err_code), 32'(v.exp_err));
        if (v.exp_err != 3'd0)
            chk(err_step == v.exp_step, "R7 error step", 32'(err_step), 32'(v.exp_step));
        chk(n_cmd == int'(v.exp_cmds), "R10 transfer count", 32'(n_cmd), 32'(v.exp_cmds));
        chk(!first_bad, "R2 first transfer is id read", 32'(first_bad), 32'd0);
        chk(!ctrl_bad, "R3 power request word", 32'(ctrl_bad), 32'd0);
        chk(!bank_bad, "R4 select word layout", 32'(bank_bad), 32'd0);
        if (v.exp_err == 3'd0 || v.exp_step != 3'd0)
            chk(dpid_valid && dpid_value == v.idv, "R2 captured id", dpid_value, v.idv);
        exp_rep = (v.exp_err == 3'd0) ? AP_LAST + 1 : ((v.exp_step == 3'd3) ? int'(v.fault_sel) : 0);
        chk(n_rep == exp_rep, "R5 report count", 32'(n_rep), 32'(exp_rep));
        for (int i = 0; i < n_rep && i < 8; i++) begin
            chk(rep_sel[i] == 8'(i), "R5 report order", 32'(rep_sel[i]), 32'(i));
            chk(rep_val[i] == ap_word(i), "R4 second buffer read reported", rep_val[i], ap_word(i));
            chk(rep_pres[i] == (ap_word(i) != 0), "R5 present flag", 32'(rep_pres[i]), 32'(ap_word(i) != 0));
        end
        repeat (3) @(negedge clk);
        chk(done == (v.exp_err == 3'd0) && err == (v.exp_err != 3'd0), "R11 state sticky",
            {30'd0, done, err}, {30'd0, v.exp_err == 3'd0, v.exp_err != 3'd0});
    endtask

    initial begin
        rst = 1'b1;
        start = 1'b0;
        n_cmd = 0; n_rep = 0;
        cfg_waits = 0; cfg_poll_at = 1; cfg_fault_sel = 511; cfg_ack = 3'b001; cfg_idv = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid && !dpid_valid && !apid_valid, "R1 state in reset",
            {26'd0, busy, done, err, cmd_valid, dpid_valid, apid_valid}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !err && !cmd_valid && n_cmd == 0, "R1 idle after reset",
            {28'd0, busy, done, err, cmd_valid}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            run(VECS[k], k == 0);
        end
        // R9: start during a busy run later in the sequence
        run(VECS[1], 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule